// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block turns one of four coil outputs on at a time, so that a unipolar permanent-magnet stepper motor steps in either direction. It runs entirely from the free-running on-chip oscillator clock. A parameterised prescaler divides that clock into a step-rate tick, and the coil pattern can change only on a tick.

Commands reach the block from one of two places. The first is a set of local switches and push buttons, which pass through a two-flop synchronizer and then a debounce filter. The second is a host controller, whose signals pass through a synchronizer only. A select input decides which source is obeyed. Start and stop are separate commands and act on their rising edges. A direction level sets the walking order of the pattern. A mode input chooses between two kinds of operation:

- **Continuous mode:** the motor runs on every tick for as long as it is started.
- **Step mode:** the motor advances once for each step request.

Top module: `stepper_seq`

## Requirements
- R1: After reset the coil output is 4'b0001, and at all times exactly one coil bit is high.
- R2: With the selected direction input high, each advance moves the single high bit one place up (0001→0010→0100→1000→0001). With it low, each advance moves the bit one place down.
- R3: The step-rate tick occurs every PRESCALE clock cycles. In continuous mode (mode input low), while started, the pattern advances on every tick, so consecutive changes are exactly PRESCALE cycles apart. The pattern never changes except one cycle after a tick.
- R4: A rising edge of start sets the running state and a rising edge of stop clears it. When both edges occur together, stop wins. While stopped, the coil output holds its last pattern.
- R5: In step mode (mode input high), each rising edge of the step request causes exactly one advance, at the next tick. Any further requests that arrive before that tick are merged into the same single advance.
- R6: When the select input is high, the host inputs are obeyed and the local inputs have no effect. When it is low, the reverse holds.
- R7: A local button level is accepted only after it has stayed stable for DEB_CYCLES clock cycles, so shorter pulses are ignored. A button held down over many ticks still produces only one action.
- R8: A direction change takes effect only at a tick. Successive coil patterns are always adjacent positions, so no position is ever skipped.
- R9: In continuous mode, step requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_host | input | 1 | Source select: 1 = host, 0 = local |
| mode_step | input | 1 | 1 = step mode, 0 = continuous mode |
| loc_start | input | 1 | Local start button |
| loc_stop | input | 1 | Local stop button |
| loc_dir | input | 1 | Local direction switch (1 = up) |
| loc_step | input | 1 | Local step button |
| host_start | input | 1 | Host start command |
| host_stop | input | 1 | Host stop command |
| host_dir | input | 1 | Host direction level (1 = up) |
| host_step | input | 1 | Host step request |
| coils | output | 4 | One-hot coil drive pattern |

## Verification
The bench times the gap between coil changes while the motor runs. If the prescaler reload were off by one, or the sequencer skipped a tick, that gap would differ from PRESCALE.

The bench also sends a burst of step requests inside one tick period. A design that counted each request, instead of merging them, would take extra steps. A stuck pending flag would make the motor keep stepping.

The bench presses start and stop together. A design without stop priority would start the motor.

The bench sends glitches shorter than the debounce window, presses buttons on the source that is not selected, and holds a button down for a long time. Each of these should produce no step, or exactly one. A weak filter, a leaky source mux, or level-triggered stepping would produce stray steps.

A direction flip made mid-run is watched for skipped positions.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int unsigned N_COILS = 4;
  localparam int unsigned IDX_W   = $clog2(N_COILS);

  typedef logic [IDX_W-1:0]   phase_idx_t;
  typedef logic [N_COILS-1:0] coil_vec_t;

  // Next position in the ring; wraps in both directions.
  function automatic phase_idx_t phase_next(input phase_idx_t cur, input logic up);
    phase_idx_t nxt;
    if (up) nxt = (cur == phase_idx_t'(N_COILS - 1)) ? '0 : cur + 1'b1;
    else    nxt = (cur == '0) ? phase_idx_t'(N_COILS - 1) : cur - 1'b1;
    return nxt;
  endfunction

  // One-hot coil pattern for a ring position.
  function automatic coil_vec_t phase_coils(input phase_idx_t cur);
    coil_vec_t v;
    v = '0;
    v[cur] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/stepper_debounce.sv
module stepper_debounce #(
  parameter int unsigned WIDTH      = 1,
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] clean
);
  localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q    <= '0;
        clean[b] <= 1'b0;
      end else if (raw[b] == clean[b]) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        cnt_q    <= '0;
        clean[b] <= raw[b];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stepper_prescaler.sv
module stepper_prescaler #(
  parameter int unsigned PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PRESCALE < 2) ? 1 : $clog2(PRESCALE);
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stepper_cmd.sv
// Command bit order in both vectors: [0] start, [1] stop, [2] direction, [3] step.
module stepper_cmd (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_cmd,
  input  logic [3:0] loc_cmd,
  input  logic       use_host,
  input  logic       step_mode,
  input  logic       tick,
  output logic       run,
  output logic       pending,
  output logic       req,
  output logic       advance,
  output logic       dir_up
);
  logic [3:0] host_q, loc_q;
  logic [3:0] host_rise, loc_rise, sel_rise;

  // Edges are found per source, before the mux, so a source switch never forms a false edge.
  assign host_rise = host_cmd & ~host_q;
  assign loc_rise  = loc_cmd  & ~loc_q;
  assign sel_rise  = use_host ? host_rise : loc_rise;
  assign dir_up    = use_host ? host_cmd[2] : loc_cmd[2];

  assign req     = step_mode & sel_rise[3];
  assign advance = tick & (step_mode ? (pending | req) : run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q  <= '0;
      loc_q   <= '0;
      run     <= 1'b0;
      pending <= 1'b0;
    end else begin
      host_q <= host_cmd;
      loc_q  <= loc_cmd;
      if (sel_rise[1])      run <= 1'b0;
      else if (sel_rise[0]) run <= 1'b1;
      if (!step_mode)       pending <= 1'b0;
      else if (tick)        pending <= 1'b0;
      else if (req)         pending <= 1'b1;
    end
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int unsigned PRESCALE   = 500000,
  parameter int unsigned DEB_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_host,
  input  logic       mode_step,
  input  logic       loc_start,
  input  logic       loc_stop,
  input  logic       loc_dir,
  input  logic       loc_step,
  input  logic       host_start,
  input  logic       host_stop,
  input  logic       host_dir,
  input  logic       host_step,
  output logic [3:0] coils
);
  logic [5:0] ctl_sync;
  logic [3:0] loc_sync, loc_clean;
  logic       tick, advance, run, pending, req, dir_up;
  logic       mode_s, src_s;
  phase_idx_t idx_q;

  stepper_sync #(.WIDTH(6)) u_sync_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({mode_step, src_host, host_step, host_dir, host_stop, host_start}),
    .q_sync  (ctl_sync)
  );

  stepper_sync #(.WIDTH(4)) u_sync_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({loc_step, loc_dir, loc_stop, loc_start}),
    .q_sync  (loc_sync)
  );

  stepper_debounce #(.WIDTH(4), .DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (loc_sync),
    .clean (loc_clean)
  );

  stepper_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign src_s  = ctl_sync[4];
  assign mode_s = ctl_sync[5];

  stepper_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cmd  (ctl_sync[3:0]),
    .loc_cmd   (loc_clean),
    .use_host  (src_s),
    .step_mode (mode_s),
    .tick      (tick),
    .run       (run),
    .pending   (pending),
    .req       (req),
    .advance   (advance),
    .dir_up    (dir_up)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= phase_next(idx_q, dir_up);
  end

  assign coils = phase_coils(idx_q);
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] coils,
  input logic       tick,
  input logic       run,
  input logic       pending,
  input logic       step_mode
);
  // R1: always exactly one coil energized
  a_r1_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(coils) == 1);

  // R8: each change moves to a neighbouring position
  a_r8_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (coils != $past(coils)) |->
      ((coils == {$past(coils[2:0]), $past(coils[3])}) ||
       (coils == {$past(coils[0]), $past(coils[3:1])})));

  // R3: the pattern only moves right after a tick
  a_r3_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (coils != $past(coils)) |-> $past(tick));

  // R3: running in continuous mode moves on every tick
  a_r3_move_each_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !step_mode) |=> (coils != $past(coils)));

  // R5: a pending request survives until a tick serves it
  a_r5_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tick && step_mode) |=> pending);
endmodule

bind stepper_seq stepper_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .coils     (coils),
  .tick      (tick),
  .run       (run),
  .pending   (pending),
  .step_mode (mode_s)
);

// File: tb/tb_stepper_seq.sv
`timescale 1ns/1ps
module tb_stepper_seq;
  localparam int PRE = 16;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_host = 1'b1;
  logic mode_step = 1'b0;
  logic [3:0] hcmd = '0;  // [0] start [1] stop [2] dir [3] step
  logic [3:0] lcmd = '0;
  logic [3:0] coils;

  int total = 0, bad = 0, cyc = 0;
  int fwd_n = 0, back_n = 0, adj_bad = 0;
  int last_chg = -1, gap_min = 1000000, gap_max = 0;
  logic [3:0] prev_coils = 4'b0001;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stepper_seq #(.PRESCALE(PRE), .DEB_CYCLES(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .src_host(src_host), .mode_step(mode_step),
    .loc_start(lcmd[0]), .loc_stop(lcmd[1]), .loc_dir(lcmd[2]), .loc_step(lcmd[3]),
    .host_start(hcmd[0]), .host_stop(hcmd[1]), .host_dir(hcmd[2]), .host_step(hcmd[3]),
    .coils(coils)
  );

  always @(posedge clk) cyc++;

  // Monitor: classify each change of the coil pattern.
  always @(negedge clk) begin
    if (rst_n && coils !== prev_coils) begin
      if (coils == {prev_coils[2:0], prev_coils[3]}) fwd_n++;
      else if (coils == {prev_coils[0], prev_coils[3:1]}) back_n++;
      else adj_bad++;
      if (last_chg >= 0) begin
        if (cyc - last_chg < gap_min) gap_min = cyc - last_chg;
        if (cyc - last_chg > gap_max) gap_max = cyc - last_chg;
      end
      last_chg = cyc;
    end
    prev_coils = coils;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk); #1;
    fwd_n = 0; back_n = 0; last_chg = -1; gap_min = 1000000; gap_max = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hpulse(input int b);
    @(negedge clk); hcmd[b] = 1'b1;
    wait_cyc(2); hcmd[b] = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    chk(coils == 4'b0001, "R1 reset pattern", coils, 1);
  endtask

  task automatic t_run_fwd();
    mode_step = 1'b0; hcmd[2] = 1'b1; wait_cyc(4);
    clr();
    hpulse(0);
    wait_cyc(6 * PRE);
    hpulse(1);
    wait_cyc(2 * PRE);
    chk(fwd_n >= 5 && back_n == 0, "R2 upward walk", fwd_n, 5);
    chk(gap_min == PRE && gap_max == PRE, "R3 gap min", gap_min, PRE);
    chk(gap_max == PRE, "R3 gap max", gap_max, PRE);
  endtask

  task automatic t_hold();
    logic [3:0] snap;
    snap = coils;
    clr();
    wait_cyc(8 * PRE);
    chk(coils == snap && fwd_n + back_n == 0, "R4 hold while stopped", coils, snap);
  endtask

  task automatic t_stop_priority();
    clr();
    @(negedge clk); hcmd[0] = 1'b1; hcmd[1] = 1'b1;
    wait_cyc(2); hcmd[0] = 1'b0; hcmd[1] = 1'b0;
    wait_cyc(5 * PRE);
    chk(fwd_n + back_n == 0, "R4 stop beats start", fwd_n + back_n, 0);
  endtask

  task automatic t_reverse();
    hcmd[2] = 1'b1; wait_cyc(4);
    hpulse(0);
    wait_cyc(3 * PRE);
    clr();
    @(negedge clk); hcmd[2] = 1'b0;
    wait_cyc(5 * PRE);
    hpulse(1);
    wait_cyc(2 * PRE);
    chk(back_n >= 4, "R2 downward walk", back_n, 4);
    chk(fwd_n <= 1, "R8 flip settles at tick", fwd_n, 0);
    chk(adj_bad == 0, "R8 no skipped position", adj_bad, 0);
  endtask

  task automatic t_step_single();
    mode_step = 1'b1; hcmd[2] = 1'b1; wait_cyc(4);
    clr();
    for (int i = 0; i < 3; i++) begin
      hpulse(3);
      wait_cyc(3 * PRE);
    end
    chk(fwd_n == 3 && back_n == 0, "R5 one advance per request", fwd_n, 3);
  endtask

  task automatic t_step_burst();
    logic [3:0] snap;
    snap = coils;
    hpulse(3);
    for (int i = 0; i < 4 * PRE && coils == snap; i++) @(negedge clk);
    clr();
    // Three requests well inside one tick period.
    for (int i = 0; i < 3; i++) begin
      hcmd[3] = 1'b1; @(negedge clk);
      hcmd[3] = 1'b0; @(negedge clk);
    end
    wait_cyc(4 * PRE);
    chk(fwd_n == 1, "R5 burst merged", fwd_n, 1);
  endtask

  task automatic t_cont_ignores_step();
    mode_step = 1'b0; wait_cyc(4);
    clr();
    hpulse(3);
    wait_cyc(3 * PRE);
    chk(fwd_n + back_n == 0, "R9 step ignored in continuous", fwd_n + back_n, 0);
  endtask

  task automatic t_src_select();
    mode_step = 1'b1; src_host = 1'b1; wait_cyc(4);
    clr();
    @(negedge clk); lcmd[3] = 1'b1;
    wait_cyc(4 * DEB + 4); lcmd[3] = 1'b0;
    wait_cyc(3 * PRE);
    chk(fwd_n + back_n == 0, "R6 local ignored under host", fwd_n + back_n, 0);
    src_host = 1'b0; lcmd[2] = 1'b1; wait_cyc(DEB + 8);
    clr();
    hpulse(3);
    wait_cyc(3 * PRE);
    chk(fwd_n + back_n == 0, "R6 host ignored under local", fwd_n + back_n, 0);
  endtask

  task automatic t_local_debounce();
    clr();
    @(negedge clk); lcmd[3] = 1'b1;
    wait_cyc(DEB - 2); lcmd[3] = 1'b0;
    wait_cyc(3 * PRE);
    chk(fwd_n + back_n == 0, "R7 short glitch ignored", fwd_n + back_n, 0);
    clr();
    @(negedge clk); lcmd[3] = 1'b1;
    wait_cyc(5 * PRE); lcmd[3] = 1'b0;
    wait_cyc(3 * PRE);
    chk(fwd_n == 1 && back_n == 0, "R7 long press one step", fwd_n, 1);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_run_fwd();
    t_hold();
    t_stop_priority();
    t_reverse();
    t_step_single();
    t_step_burst();
    t_cont_ignores_step();
    t_src_select();
    t_local_debounce();
    chk(adj_bad == 0, "R8 adjacency over run", adj_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule